// File: doc/BRIEF.md
# Modulo-Scheduled Initiation State Tracker

This block walks the state diagram of one pipeline class operating under a modulo schedule with initiation interval `II`. Its state is a bit-vector with one bit per latency 0..II-1. A set bit means that a new initiation, offset by that many cycles from the most recent one, does not collide with any earlier initiation in the wrapped II-cycle window. A scheduler or a design-space explorer first loads the class's starting permissible set, which stands for an initiation at time 0. It then offers candidate latencies one at a time. The block replies whether each candidate fits and, when it does, advances to the successor state.

To advance on an accepted latency p, the block rotates the current set down by p modulo II. Bit r of the rotated set takes bit (r+p) mod II of the old set. The result is then masked with the starting set captured at the last start. The block also keeps the number of initiations placed so far, counting the one at time 0, and the sum of the accepted latencies, which is the issue time of the latest initiation. A dead output shows when no latency is permissible any more.

Top module: `mod_init_tracker`

## Requirements
- R1: On reset, and on a cycle with `start` high, the block captures `init_set` with bit 0 forced to 0 as the starting set. `perm_set` then equals this set, `init_count` is 1, `issue_time` is 0 and `resp_valid` is 0 in the following cycle.
- R2: A request with `req_lat` in 1..II-1 whose bit in `perm_set` is 1 is accepted. One cycle later `resp_valid` is 1 and `resp_accept` is 1.
- R3: After an accepted latency p, bit r of `perm_set` equals bit (r+p) mod II of the previous `perm_set` ANDed with bit r of the starting set.
- R4: Each accepted request increments `init_count` by 1 and adds p to `issue_time`. Accepted latencies p1..pk therefore give initiation times 0, p1, ..., p1+...+pk.
- R5: A request whose latency bit is 0 in `perm_set`, or whose `req_lat` is 0 or at least II, is rejected. One cycle later `resp_valid` is 1 and `resp_accept` is 0, and `perm_set`, `init_count` and `issue_time` are unchanged.
- R6: `dead` is 1 exactly when `perm_set` is all zero. Once dead, the state stays empty until the next start.
- R7: When `start` and `req_valid` are high in the same cycle, the start wins. The request gets no response and does not alter the reloaded state.
- R8: `resp_valid` is 1 only in the cycle after a request that was not overridden by a start.
- R9: The mask applied in R3 is the set captured at the last start or reset. Later changes on `init_set` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Reload the starting set from `init_set` |
| init_set | input | II | Starting permissible set, bit q = latency q |
| req_valid | input | 1 | Latency request present |
| req_lat | input | clog2(II) | Requested latency |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_accept | output | 1 | Request was accepted |
| perm_set | output | II | Current permissible latency set |
| init_count | output | clog2(II+1) | Initiations placed, including time 0 |
| issue_time | output | clog2(II*II+1) | Time of the latest initiation |
| dead | output | 1 | No latency is permissible |

## Verification
The block is driven with three kinds of starting set. The first is one whose every latency leads straight to the empty set ({1,3,5} at II=6), which separates a correct mask from a missing one. The second is a set holding several short progressions ({1,2,4,5} at II=6), where the sequences 1,1, 2,2 and 4,1 each reach three initiations. These show that the rotation direction and the modulo wrap are right. The third is a long progression at II=12 ({3,6,9} and {2,4,6,8,10}), where repeated equal latencies must give one initiation more than the progression length, with exact accumulated times. Rejections are tried with latencies absent from the set, latency 0, latencies at or above II, and requests on a dead state. Separate cases cover a start that collides with a request and a change of `init_set` after the start.

// File: rtl/mod_init_tracker.sv
module mod_init_tracker #(
  parameter int II = 12,
  localparam int LW = $clog2(II),
  localparam int CW = $clog2(II + 1),
  localparam int TW = $clog2(II * II + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [II-1:0] init_set,
  input  logic          req_valid,
  input  logic [LW-1:0] req_lat,
  output logic          resp_valid,
  output logic          resp_accept,
  output logic [II-1:0] perm_set,
  output logic [CW-1:0] init_count,
  output logic [TW-1:0] issue_time,
  output logic          dead
);

  logic [II-1:0] s0_q, set_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] time_q;
  logic          rv_q, ra_q;

  wire [II-1:0] init_clean = init_set & {{(II-1){1'b1}}, 1'b0};
  wire          in_range   = (req_lat != '0) && (32'(req_lat) < II);
  wire [II-1:0] lat_bit    = {{(II-1){1'b0}}, 1'b1} << req_lat;
  wire          hit        = in_range && |(set_q & lat_bit);
  wire [II-1:0] rot        = (set_q >> req_lat) | (set_q << (II - 32'(req_lat)));
  wire          take       = req_valid && !start && hit;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      s0_q   <= init_clean;
      set_q  <= init_clean;
      cnt_q  <= CW'(1);
      time_q <= '0;
      rv_q   <= 1'b0;
      ra_q   <= 1'b0;
    end else begin
      rv_q <= req_valid;
      ra_q <= req_valid && hit;
      if (take) begin
        set_q  <= rot & s0_q;
        cnt_q  <= cnt_q + CW'(1);
        time_q <= time_q + TW'(req_lat);
      end
    end
  end

  assign resp_valid  = rv_q;
  assign resp_accept = ra_q;
  assign perm_set    = set_q;
  assign init_count  = cnt_q;
  assign issue_time  = time_q;
  assign dead        = (set_q == '0);

endmodule

// File: rtl/mod_init_tracker_chk.sv
module mod_init_tracker_chk #(
  parameter int II = 12,
  localparam int LW = $clog2(II),
  localparam int CW = $clog2(II + 1),
  localparam int TW = $clog2(II * II + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req_valid,
  input logic [LW-1:0] req_lat,
  input logic          resp_valid,
  input logic          resp_accept,
  input logic [II-1:0] perm_set,
  input logic [CW-1:0] init_count,
  input logic [TW-1:0] issue_time,
  input logic          dead,
  input logic [II-1:0] s0_q
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && !start)); // R8

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_accept) |-> ($stable(perm_set) && $stable(init_count) && $stable(issue_time))); // R5

  AST_ACCEPT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept) |-> (init_count == $past(init_count) + CW'(1))); // R4

  AST_ACCEPT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept) |-> (issue_time == $past(issue_time) + TW'($past(req_lat)))); // R4

  AST_ACCEPT_WAS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept) |-> ((($past(perm_set) >> $past(req_lat)) & II'(1)) != '0)); // R2

  AST_SUBSET_OF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_set & ~s0_q) == '0); // R3

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && !start) |=> dead); // R6

  AST_NO_ZERO_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_set[0]); // R1

endmodule

bind mod_init_tracker mod_init_tracker_chk #(.II(II)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_lat(req_lat), .resp_valid(resp_valid), .resp_accept(resp_accept),
  .perm_set(perm_set), .init_count(init_count), .issue_time(issue_time),
  .dead(dead), .s0_q(s0_q)
);

// File: tb/test_mod_init_tracker.sv
module test_mod_init_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 27;

  // {sel, start, s0[11:0], lat[3:0], acc, cnt[3:0], time[7:0], set[11:0]}
  localparam logic [42:0] VECS [0:NV-1] = '{
    {1'b0,1'b1,12'h248,4'd0,1'b0,4'd1,8'd0, 12'h248},  // R1
    {1'b0,1'b0,12'h000,4'd4,1'b0,4'd1,8'd0, 12'h248},  // R5 not in set
    {1'b0,1'b0,12'h000,4'd3,1'b1,4'd2,8'd3, 12'h048},  // R2 R3 R4
    {1'b0,1'b0,12'h000,4'd3,1'b1,4'd3,8'd6, 12'h008},
    {1'b0,1'b0,12'h000,4'd3,1'b1,4'd4,8'd9, 12'h000},  // R6
    {1'b0,1'b0,12'h000,4'd3,1'b0,4'd4,8'd9, 12'h000},  // R5 R6 dead
    {1'b0,1'b1,12'h554,4'd0,1'b0,4'd1,8'd0, 12'h554},
    {1'b0,1'b0,12'h000,4'd2,1'b1,4'd2,8'd2, 12'h154},
    {1'b0,1'b0,12'h000,4'd2,1'b1,4'd3,8'd4, 12'h054},
    {1'b0,1'b0,12'h000,4'd2,1'b1,4'd4,8'd6, 12'h014},
    {1'b0,1'b0,12'h000,4'd2,1'b1,4'd5,8'd8, 12'h004},
    {1'b0,1'b0,12'h000,4'd2,1'b1,4'd6,8'd10,12'h000},
    {1'b0,1'b0,12'h000,4'd13,1'b0,4'd6,8'd10,12'h000}, // R5 range
    {1'b1,1'b1,12'h02A,4'd0,1'b0,4'd1,8'd0, 12'h02A},
    {1'b1,1'b0,12'h000,4'd3,1'b1,4'd2,8'd3, 12'h000},  // R3 empty
    {1'b1,1'b1,12'h036,4'd0,1'b0,4'd1,8'd0, 12'h036},
    {1'b1,1'b0,12'h000,4'd1,1'b1,4'd2,8'd1, 12'h012},
    {1'b1,1'b0,12'h000,4'd1,1'b1,4'd3,8'd2, 12'h000},
    {1'b1,1'b1,12'h036,4'd0,1'b0,4'd1,8'd0, 12'h036},
    {1'b1,1'b0,12'h000,4'd2,1'b1,4'd2,8'd2, 12'h024},
    {1'b1,1'b0,12'h000,4'd2,1'b1,4'd3,8'd4, 12'h000},
    {1'b1,1'b1,12'h036,4'd0,1'b0,4'd1,8'd0, 12'h036},
    {1'b1,1'b0,12'h000,4'd4,1'b1,4'd2,8'd4, 12'h012},  // R3 wrap
    {1'b1,1'b0,12'h000,4'd1,1'b1,4'd3,8'd5, 12'h000},
    {1'b1,1'b1,12'h037,4'd0,1'b0,4'd1,8'd0, 12'h036},  // R1 bit0
    {1'b1,1'b0,12'h000,4'd6,1'b0,4'd1,8'd0, 12'h036},  // R5 lat=II
    {1'b1,1'b0,12'h000,4'd0,1'b0,4'd1,8'd0, 12'h036}   // R5 lat 0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        st_a = 1'b0, rq_a = 1'b0;
  logic [11:0] in_a = 12'h248;
  logic [3:0]  lt_a = '0;
  logic        rv_a, ra_a, dd_a;
  logic [11:0] ps_a;
  logic [3:0]  ic_a;
  logic [7:0]  it_a;

  logic        st_b = 1'b0, rq_b = 1'b0;
  logic [5:0]  in_b = 6'h36;
  logic [2:0]  lt_b = '0;
  logic        rv_b, ra_b, dd_b;
  logic [5:0]  ps_b;
  logic [2:0]  ic_b;
  logic [5:0]  it_b;

  mod_init_tracker #(.II(12)) i_mod_init_tracker (
    .clk(clk), .rst_n(rst_n), .start(st_a), .init_set(in_a),
    .req_valid(rq_a), .req_lat(lt_a), .resp_valid(rv_a), .resp_accept(ra_a),
    .perm_set(ps_a), .init_count(ic_a), .issue_time(it_a), .dead(dd_a));

  mod_init_tracker #(.II(6)) i_mod_init_tracker_ii6 (
    .clk(clk), .rst_n(rst_n), .start(st_b), .init_set(in_b),
    .req_valid(rq_b), .req_lat(lt_b), .resp_valid(rv_b), .resp_accept(ra_b),
    .perm_set(ps_b), .init_count(ic_b), .issue_time(it_b), .dead(dd_b));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic drive(input bit sel, input bit st, input logic [11:0] s0,
                       input bit rq, input logic [3:0] lat);
    @(negedge clk);
    if (!sel) begin
      st_a = st; rq_a = rq; lt_a = lat;
      if (st) in_a = s0;
    end else begin
      st_b = st; rq_b = rq; lt_b = lat[2:0];
      if (st) in_b = s0[5:0];
    end
    @(negedge clk);
    st_a = 1'b0; rq_a = 1'b0; st_b = 1'b0; rq_b = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset set", int'(ps_a), 'h248);
    chk("R1 reset count", int'(ic_a), 1);
    chk("R1 reset time", int'(it_a), 0);
    chk("R8 reset resp", int'(rv_a), 0);
    chk("R6 reset dead", int'(dd_a), 0);
    chk("R1 reset set ii6", int'(ps_b), 'h36);

    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      int set_e, acc_e;
      e = VECS[v];
      drive(e[42], e[41], e[40:29], !e[41], e[28:25]);
      set_e = int'(e[11:0]);
      acc_e = int'(e[24]);
      if (!e[42]) begin
        chk(e[41] ? "R8 no resp on start" : "R2 R5 resp_valid", int'(rv_a), e[41] ? 0 : 1);
        if (!e[41]) chk("R2 R5 accept", int'(ra_a), acc_e);
        chk("R3 set", int'(ps_a), set_e);
        chk("R4 count", int'(ic_a), int'(e[23:20]));
        chk("R4 time", int'(it_a), int'(e[19:12]));
        chk("R6 dead", int'(dd_a), set_e == 0 ? 1 : 0);
      end else begin
        chk(e[41] ? "R8 no resp on start ii6" : "R2 R5 resp_valid ii6", int'(rv_b), e[41] ? 0 : 1);
        if (!e[41]) chk("R2 R5 accept ii6", int'(ra_b), acc_e);
        chk("R3 set ii6", int'(ps_b), set_e);
        chk("R4 count ii6", int'(ic_b), int'(e[23:20]));
        chk("R4 time ii6", int'(it_b), int'(e[19:12]));
        chk("R6 dead ii6", int'(dd_b), set_e == 0 ? 1 : 0);
      end
    end

    // R8: idle cycle after a response
    @(negedge clk);
    chk("R8 idle resp", int'(rv_a), 0);

    // R7: start collides with a request
    drive(1'b0, 1'b0, 12'h0, 1'b1, 4'd3);
    @(negedge clk);
    st_a = 1'b1; in_a = 12'h248; rq_a = 1'b1; lt_a = 4'd3;
    @(negedge clk);
    st_a = 1'b0; rq_a = 1'b0;
    chk("R7 no resp", int'(rv_a), 0);
    chk("R7 set reloaded", int'(ps_a), 'h248);
    chk("R7 count", int'(ic_a), 1);
    chk("R7 time", int'(it_a), 0);

    // R9: init_set changes after start do not alter the mask
    in_a = 12'h000;
    drive(1'b0, 1'b0, 12'h0, 1'b1, 4'd3);
    chk("R9 accept", int'(ra_a), 1);
    chk("R9 old mask kept", int'(ps_a), 'h048);
    chk("R9 count", int'(ic_a), 2);

    summary();
    $finish;
  end
endmodule